// File: doc/BRIEF.md
# Stream DMA Descriptor Sequencer

This block is the control core of a single audio DMA stream. Software programs two small registers through a 16-bit register port. The first holds the index of the final valid buffer descriptor in a circular list. The second holds a FIFO threshold code. Once the run bit is raised, the block keeps a current descriptor index. Each descriptor-completion pulse advances the index, and after the final valid entry the index returns to zero.

The block also watches the stream FIFO's byte occupancy and raises a transfer request. In the playback direction this is a request to fetch more data, made once enough bytes are free. In the capture direction it is a request to evict data, made once enough bytes have piled up. The request is a level. It stays high until the bus side acknowledges it and drops whenever the stream is stopped.

A start attempt with a final index of zero is refused and flagged. Threshold codes the block does not support are replaced with the 32-byte code, so a readback shows software what was actually kept.

Top module: `sdseq_top`

## Requirements
- R1: After reset, the final-index register reads 0000h, the threshold register reads 0004h, the current index is 0, and both the request and the configuration-error outputs are low.
- R2: With reg_sel_i = 0 the port addresses the final-index register. Only bits 7:0 are stored, and bits 15:8 always read as zero.
- R3: A write to the final-index register made while run_i is 1 leaves the stored value unchanged.
- R4: When run_i goes from 0 to 1 with a final index of at least 1, the stream becomes active and the current index becomes 0. Each desc_done_i pulse while active moves the index up by one.
- R5: A desc_done_i pulse while the current index equals the final index returns the current index to 0.
- R6: When run_i rises while the final index is 0, cfg_err_o goes high on the following cycle and the stream stays inactive: the index does not move and no request is raised. cfg_err_o clears once run_i returns to 0.
- R7: With reg_sel_i = 1 the port addresses the threshold register, whose code lives in bits 2:0 and whose bits 15:3 read as zero. Codes 010, 011 and 100 mean 8, 16 and 32 bytes. Writing any other code stores 100.
- R8: While active, a request is raised one cycle after the threshold is met. With dir_in_i = 0 (playback) the threshold is met when FIFO_DEPTH minus fifo_occ_i is at least the threshold bytes. With dir_in_i = 1 (capture) it is met when fifo_occ_i is at least the threshold bytes.
- R9: A raised request stays high, whatever the occupancy does, until a cycle with xfer_ack_i = 1. That cycle clears it.
- R10: While run_i is 0, xfer_req_o goes low one cycle later and stays low, and desc_done_i pulses leave the current index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 final index, 1 threshold |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for the selected register (combinational) |
| run_i | input | 1 | Stream run enable |
| dir_in_i | input | 1 | Direction: 0 playback (fetch), 1 capture (evict) |
| desc_done_i | input | 1 | One-cycle pulse: current descriptor completed |
| fifo_occ_i | input | 7 | FIFO byte occupancy |
| xfer_ack_i | input | 1 | Acknowledge of the pending request |
| xfer_req_o | output | 1 | Fetch or evict request level |
| cur_idx_o | output | 8 | Current descriptor index |
| cfg_err_o | output | 1 | Start refused because the final index is 0 |

## Verification
The bench walks all eight threshold codes, including codes 000, 001 and 101 through 111. A design that stored an unsupported code as written would read it back, and its request threshold would drift. It attempts a start with a final index of zero. A faulty design would either start and advance the index or raise a request anyway. It also writes the final index in the middle of a run and then steps the index past the old final entry. A write that got through would move the wrap point, and the index would run on past 3. Finally, it holds a request while the occupancy falls back below the threshold and while the run bit drops. A design that tied the request to the threshold would release it early, and one that ignored the run bit would keep asking after the stop.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

    localparam logic [2:0] WM_CODE_DEFAULT = 3'b100;

    typedef enum logic {
        SEL_LAST_IDX  = 1'b0,
        SEL_WATERMARK = 1'b1
    } reg_sel_e;

    function automatic logic wm_code_ok(logic [2:0] code);
        return (code == 3'b010) || (code == 3'b011) || (code == 3'b100);
    endfunction

    function automatic logic [5:0] wm_bytes(logic [2:0] code);
        case (code)
            3'b010:  return 6'd8;
            3'b011:  return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/sdseq_regs.sv
module sdseq_regs
    import sdseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              run_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [IDX_W-1:0]  lvi_o,
    output logic [2:0]        wm_o
);

    typedef struct packed {
        logic [IDX_W-1:0] lvi;
        logic [2:0]       wm;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            if (reg_sel_e'(sel_i) == SEL_LAST_IDX) begin
                if (!run_i) begin
                    st_d.lvi = wdata_i[IDX_W-1:0];
                end
            end else begin
                st_d.wm = wm_code_ok(wdata_i[2:0]) ? wdata_i[2:0] : WM_CODE_DEFAULT;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.lvi <= '0;
            st_q.wm  <= WM_CODE_DEFAULT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (reg_sel_e'(sel_i) == SEL_LAST_IDX) begin
            rdata_o[IDX_W-1:0] = st_q.lvi;
        end else begin
            rdata_o[2:0] = st_q.wm;
        end
    end

    assign lvi_o = st_q.lvi;
    assign wm_o  = st_q.wm;

    AST_LVI_FROZEN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |=> $stable(st_q.lvi)); // R3

    AST_WM_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.wm == 3'b010) || (st_q.wm == 3'b011) || (st_q.wm == 3'b100)); // R7

    AST_WM_COERCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && sel_i && !wm_code_ok(wdata_i[2:0])) |=> (st_q.wm == 3'b100)); // R7

endmodule

// File: rtl/sdseq_index.sv
module sdseq_index #(
    parameter int IDX_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             done_i,
    input  logic [IDX_W-1:0] lvi_i,
    output logic             active_o,
    output logic             err_o,
    output logic [IDX_W-1:0] idx_o
);

    typedef struct packed {
        logic             run_q;
        logic             active;
        logic             err;
        logic [IDX_W-1:0] idx;
    } idx_st_t;

    idx_st_t st_d, st_q;
    logic    start;

    assign start = run_i && !st_q.run_q;

    always_comb begin
        st_d       = st_q;
        st_d.run_q = run_i;
        if (!run_i) begin
            st_d.active = 1'b0;
            st_d.err    = 1'b0;
        end else if (start) begin
            st_d.idx = '0;
            if (lvi_i == '0) begin
                st_d.err    = 1'b1;
                st_d.active = 1'b0;
            end else begin
                st_d.err    = 1'b0;
                st_d.active = 1'b1;
            end
        end else if (st_q.active && done_i) begin
            st_d.idx = (st_q.idx == lvi_i) ? '0 : st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign err_o    = st_q.err;
    assign idx_o    = st_q.idx;

    AST_IDX_IN_LIST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.active |-> (st_q.idx <= lvi_i)); // R5

    AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active && run_i && done_i && (st_q.idx == lvi_i)) |=> (st_q.idx == '0)); // R5

    AST_START_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start && (lvi_i == '0)) |=> (st_q.err && !st_q.active)); // R6

    AST_IDX_STILL_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> $stable(st_q.idx)); // R10

endmodule

// File: rtl/sdseq_req.sv
module sdseq_req
    import sdseq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int OCC_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             active_i,
    input  logic             run_i,
    input  logic             dir_in_i,
    input  logic [2:0]       wm_i,
    input  logic [OCC_W-1:0] occ_i,
    input  logic             ack_i,
    output logic             req_o
);

    typedef struct packed {
        logic req;
    } req_st_t;

    req_st_t     st_d, st_q;
    logic [31:0] thresh;
    logic [31:0] level;
    logic        met;

    always_comb begin
        thresh = 32'(wm_bytes(wm_i));
        if (dir_in_i) begin
            level = 32'(occ_i);
        end else if (32'(occ_i) >= 32'(DEPTH)) begin
            level = '0;
        end else begin
            level = 32'(DEPTH) - 32'(occ_i);
        end
        met = (level >= thresh);
    end

    always_comb begin
        st_d = st_q;
        if (!(active_i && run_i)) begin
            st_d.req = 1'b0;
        end else if (st_q.req) begin
            st_d.req = !ack_i;
        end else begin
            st_d.req = met;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.req;

    AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.req && !ack_i && run_i && active_i) |=> st_q.req); // R9

    AST_REQ_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.req && ack_i) |=> !st_q.req); // R9

    AST_REQ_OFF_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> !st_q.req); // R10

endmodule

// File: rtl/sdseq_top.sv
module sdseq_top #(
    parameter int DATA_W     = 16,
    parameter int IDX_W      = 8,
    parameter int FIFO_DEPTH = 64,
    localparam int OCC_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic              reg_sel_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              run_i,
    input  logic              dir_in_i,
    input  logic              desc_done_i,
    input  logic [OCC_W-1:0]  fifo_occ_i,
    input  logic              xfer_ack_i,
    output logic              xfer_req_o,
    output logic [IDX_W-1:0]  cur_idx_o,
    output logic              cfg_err_o
);

    logic [IDX_W-1:0] lvi;
    logic [2:0]       wm;
    logic             active;

    sdseq_regs #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (reg_wr_i),
        .sel_i   (reg_sel_i),
        .wdata_i (reg_wdata_i),
        .run_i   (run_i),
        .rdata_o (reg_rdata_o),
        .lvi_o   (lvi),
        .wm_o    (wm)
    );

    sdseq_index #(
        .IDX_W (IDX_W)
    ) u_index (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_i),
        .done_i   (desc_done_i),
        .lvi_i    (lvi),
        .active_o (active),
        .err_o    (cfg_err_o),
        .idx_o    (cur_idx_o)
    );

    sdseq_req #(
        .DEPTH (FIFO_DEPTH),
        .OCC_W (OCC_W)
    ) u_req (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (active),
        .run_i    (run_i),
        .dir_in_i (dir_in_i),
        .wm_i     (wm),
        .occ_i    (fifo_occ_i),
        .ack_i    (xfer_ack_i),
        .req_o    (xfer_req_o)
    );

    AST_ERR_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |=> !xfer_req_o); // R6

endmodule

// File: tb/sdseq_top_tb.sv
module sdseq_top_tb;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        run = 1'b0;
    logic        dir_in = 1'b0;
    logic        done = 1'b0;
    logic [6:0]  occ = '0;
    logic        ack = 1'b0;
    logic        req;
    logic [7:0]  idx;
    logic        err;

    int n_checks = 0;
    int n_errors = 0;
    string phase = "R1";

    int m_lvi = 0, m_wm = 4, m_runq = 0, m_act = 0, m_err = 0, m_idx = 0, m_req = 0;

    always #5 clk = ~clk;

    sdseq_top u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_sel_i   (reg_sel),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .run_i       (run),
        .dir_in_i    (dir_in),
        .desc_done_i (done),
        .fifo_occ_i  (occ),
        .xfer_ack_i  (ack),
        .xfer_req_o  (req),
        .cur_idx_o   (idx),
        .cfg_err_o   (err)
    );

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int threshold_met(int wm, int o, int d);
        int need = 1 << (wm + 1);
        if (d != 0) return (o >= need) ? 1 : 0;
        return ((DEPTH - o) >= need) ? 1 : 0;
    endfunction

    // Behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lvi <= 0; m_wm <= 4; m_runq <= 0; m_act <= 0;
            m_err <= 0; m_idx <= 0; m_req <= 0;
        end else begin
            int c;
            c = int'(reg_wdata[2:0]);
            if (reg_wr) begin
                if (!reg_sel) begin
                    if (!run) m_lvi <= int'(reg_wdata) % 256;
                end else begin
                    m_wm <= (c >= 2 && c <= 4) ? c : 4;
                end
            end
            if (!run) begin
                m_act <= 0; m_err <= 0;
            end else if (m_runq == 0) begin
                m_idx <= 0;
                if (m_lvi == 0) m_err <= 1; else m_act <= 1;
            end else if (m_act != 0 && done) begin
                m_idx <= (m_idx == m_lvi) ? 0 : m_idx + 1;
            end
            if (!(m_act != 0 && run)) m_req <= 0;
            else if (m_req != 0) m_req <= ack ? 0 : 1;
            else m_req <= threshold_met(m_wm, int'(occ), int'(dir_in));
            m_runq <= run ? 1 : 0;
        end
    end

    // Per-clock comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk({phase, " idx"}, int'(idx), m_idx);
            chk({phase, " req"}, int'(req), m_req);
            chk({phase, " err"}, int'(err), m_err);
            chk({phase, " rdata"}, int'(reg_rdata), reg_sel ? m_wm : m_lvi);
        end
    end

    task automatic wr(logic sel, logic [15:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic sel, int exp);
        reg_sel = sel;
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic pulse_done();
        @(negedge clk); done = 1'b1;
        @(negedge clk); done = 1'b0;
        #1;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        #1;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        phase = "R1";
        rd_chk("R1 last index reset", 1'b0, 0);
        rd_chk("R1 threshold reset", 1'b1, 4);
        chk("R1 index reset", int'(idx), 0);
        chk("R1 request reset", int'(req), 0);
        chk("R1 error reset", int'(err), 0);

        // R2 field width
        phase = "R2";
        wr(1'b0, 16'hFFFF);
        rd_chk("R2 upper bits zero", 1'b0, 16'h00FF);

        // R7 every code
        phase = "R7";
        for (int c = 0; c < 8; c++) begin
            wr(1'b1, 16'hFFF8 | 16'(c));
            rd_chk("R7 threshold readback", 1'b1, (c >= 2 && c <= 4) ? c : 4);
        end

        // R6 refused start
        phase = "R6";
        wr(1'b0, 16'h0000);
        @(negedge clk); run = 1'b1;
        wait_cyc(2);
        chk("R6 error flagged", int'(err), 1);
        pulse_done();
        pulse_done();
        chk("R6 index frozen", int'(idx), 0);
        chk("R6 no request", int'(req), 0);
        @(negedge clk); run = 1'b0;
        wait_cyc(1);
        chk("R6 error cleared", int'(err), 0);

        // R4 / R5 stepping and wrap
        phase = "R4";
        wr(1'b0, 16'h0003);
        wr(1'b1, 16'h0004);
        @(negedge clk); run = 1'b1;
        wait_cyc(1);
        chk("R4 index at start", int'(idx), 0);
        for (int k = 1; k <= 3; k++) begin
            pulse_done();
            chk("R4 index advance", int'(idx), k);
        end
        phase = "R5";
        pulse_done();
        chk("R5 wrap to zero", int'(idx), 0);
        pulse_done();
        chk("R5 after wrap", int'(idx), 1);

        // R3 write ignored while running
        phase = "R3";
        wr(1'b0, 16'h0009);
        rd_chk("R3 last index kept", 1'b0, 3);
        pulse_done(); pulse_done(); pulse_done();
        chk("R3 wrap point unchanged", int'(idx), 0);

        // R8 thresholds, R9 hold
        phase = "R8";
        @(negedge clk); occ = 7'd40; dir_in = 1'b0;
        pulse_ack();
        wait_cyc(2);
        chk("R8 playback below threshold", int'(req), 0);
        @(negedge clk); occ = 7'd32;
        wait_cyc(1);
        chk("R8 playback threshold met", int'(req), 1);
        phase = "R9";
        @(negedge clk); occ = 7'd60;
        wait_cyc(3);
        chk("R9 request held", int'(req), 1);
        pulse_ack();
        chk("R9 ack clears", int'(req), 0);
        wait_cyc(2);
        chk("R9 stays low unmet", int'(req), 0);
        phase = "R8";
        @(negedge clk); dir_in = 1'b1;
        wait_cyc(1);
        chk("R8 capture threshold met", int'(req), 1);
        wr(1'b1, 16'h0002);
        @(negedge clk); occ = 7'd10;
        pulse_ack();
        wait_cyc(1);
        chk("R8 capture 8 byte met", int'(req), 1);
        @(negedge clk); occ = 7'd7;
        pulse_ack();
        wait_cyc(2);
        chk("R8 capture 8 byte unmet", int'(req), 0);
        @(negedge clk); occ = 7'd8;
        wait_cyc(2);

        // R10 stopped
        phase = "R10";
        @(negedge clk); run = 1'b0;
        wait_cyc(1);
        chk("R10 request dropped", int'(req), 0);
        begin
            int held;
            held = int'(idx);
            pulse_done(); pulse_done();
            chk("R10 index unchanged", int'(idx), held);
        end
        wait_cyc(2);
        chk("R10 request still low", int'(req), 0);

        phase = "R4";
        @(negedge clk); run = 1'b1;
        wait_cyc(1);
        chk("R4 restart index zero", int'(idx), 0);
        wait_cyc(3);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule